// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a register-mapped watchdog built around a 64-bit up-counter and a 64-bit period. Each is reachable as two 32-bit words. Software first configures the block: the counter, the period, a global control word that releases both counter halves and selects watchdog mode, and a timer control word that sets the run mode. It then arms the watchdog by writing an ordered pair of 16-bit keys into the key field of the watchdog control word.

The first key, written with the enable bit set, moves the block to a pre-active state. From that point every configuration write is dropped. Only the key field still has any effect. The second key then makes the watchdog active, and the counter starts running. While the watchdog is active, software must keep writing the same key pair. Each complete pair restarts the count from zero.

If the running count reaches the period, the block sets a sticky flag and drives a reset-request pulse of fixed length. The counter then stops.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset every register reads zero and `wd_rst_req` is low.
- R2: Before arming, the counter halves (byte offsets 0x10 low, 0x14 high) and the period halves (0x18 low, 0x1C high) read back whatever was written to them. Timer control (0x20) keeps only bits 7:6. Global control (0x24) keeps only bits 3:0. Watchdog control (0x28) keeps only the enable bit, bit 14. Its key field (bits 31:16) reads zero, and its flag bit (bit 15) cannot be written.
- R3: Writing key 0xA5C6 into bits 31:16 of 0x28 with bit 14 set moves the block to pre-active. The counter does not run in pre-active. Writing key 0xDA7E with bit 14 set then makes the block active. Key 0xA5C6 written without bit 14 does not arm the block.
- R4: From pre-active onward, writes to 0x10 through 0x24 and to the non-key bits of 0x28 are ignored.
- R5: The counter advances by one per clock only when all of the following hold: global control bits 1:0 are both 1, bits 3:2 equal 2, timer control bits 7:6 are nonzero, and the block is active.
- R6: While the block is active, key 0xA5C6 followed by key 0xDA7E clears the counter in the cycle the second key is written. Counting then resumes from zero.
- R7: A write to 0x28 that breaks the sequence (wrong key, or a key field of zero) returns the key tracker to its last stable state (pre-active or active) with no service. Key 0xA5C6 always restarts the sequence. Key 0xDA7E written while disarmed has no effect.
- R8: When the running counter equals the period, bit 15 of 0x28 is set, `wd_rst_req` is high for exactly REQ_CYCLES (16) clocks, and the counter holds its value.
- R9: The flag stays set until `rst_n` is asserted. Register writes and service sequences do not clear it.
- R10: If a service completes in the same cycle that the count equals the period, the service wins: the counter clears and no expiry occurs.
- R11: The low counter half carries into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_rst_req | output | 1 | Reset request raised on expiry |

## Verification
A service and an expiry can fall in the same cycle. This happens when the second key lands exactly as the count reaches the period. The bench arms the block with an 8-cycle period, waits a computed number of idle cycles, and issues the key pair so that the second key lands one cycle before the match, on the match itself, and one cycle after it. It judges each case by the flag, the reset request and the counter value read right after the second key: the flag must stay clear in the first two cases and be set in the third.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W     = 6,
  parameter int REQ_CYCLES = 16,
  parameter logic [15:0] KEY_A = 16'hA5C6,
  parameter logic [15:0] KEY_B = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_rst_req
);
  localparam int PW = $clog2(REQ_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_PRD_LO = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_PRD_HI = ADDR_W'(28);
  localparam logic [ADDR_W-1:0] A_TCTL   = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] A_GCTL   = ADDR_W'(36);
  localparam logic [ADDR_W-1:0] A_WCTL   = ADDR_W'(40);

  typedef enum logic [1:0] {S_OFF, S_PRE, S_ACT, S_SVC} kstate_t;

  kstate_t         kst;
  logic [63:0]     cnt, prd;
  logic [1:0]      emode;
  logic [3:0]      gctl;
  logic            wden, flag;
  logic [PW-1:0]   pulse;

  wire [15:0] key      = bus_wdata[31:16];
  wire        wr_ctl   = bus_we && bus_addr == A_WCTL;
  wire        key_a    = wr_ctl && key == KEY_A;
  wire        key_b    = wr_ctl && key == KEY_B;
  wire        locked   = kst != S_OFF;
  wire        cfg_we   = bus_we && !locked;
  wire        active   = kst == S_ACT || kst == S_SVC;
  wire        pre_act  = kst == S_PRE;
  wire        run      = active && gctl[1:0] == 2'b11 && gctl[3:2] == 2'b10 &&
                         emode != 2'b00 && !flag;
  wire        service  = kst == S_SVC && key_b;
  wire        expire   = run && cnt == prd && !service;

  assign wd_rst_req = pulse != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) kst <= S_OFF;
    else case (kst)
      S_OFF: if (key_a && bus_wdata[14]) kst <= S_PRE;
      S_PRE: if (key_b && bus_wdata[14]) kst <= S_ACT;
      S_ACT: if (key_a) kst <= S_SVC;
      default: begin
        if (key_b)       kst <= S_ACT;
        else if (key_a)  kst <= S_SVC;
        else if (wr_ctl) kst <= S_ACT;
      end
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prd   <= '0;
      emode <= '0;
      gctl  <= '0;
      wden  <= 1'b0;
    end else if (cfg_we) begin
      if (bus_addr == A_PRD_LO) prd[31:0]  <= bus_wdata;
      if (bus_addr == A_PRD_HI) prd[63:32] <= bus_wdata;
      if (bus_addr == A_TCTL)   emode      <= bus_wdata[7:6];
      if (bus_addr == A_GCTL)   gctl       <= bus_wdata[3:0];
      if (bus_addr == A_WCTL)   wden       <= bus_wdata[14];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               cnt <= '0;
    else if (cfg_we && bus_addr == A_CNT_LO)  cnt[31:0]  <= bus_wdata;
    else if (cfg_we && bus_addr == A_CNT_HI)  cnt[63:32] <= bus_wdata;
    else if (service)                         cnt <= '0;
    else if (run && !expire)                  cnt <= cnt + 64'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag  <= 1'b0;
      pulse <= '0;
    end else if (expire) begin
      flag  <= 1'b1;
      pulse <= PW'(REQ_CYCLES);
    end else if (pulse != '0) begin
      pulse <= pulse - PW'(1);
    end

  always_comb
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[31:0];
      A_CNT_HI: bus_rdata = cnt[63:32];
      A_PRD_LO: bus_rdata = prd[31:0];
      A_PRD_HI: bus_rdata = prd[63:32];
      A_TCTL:   bus_rdata = {24'd0, emode, 6'd0};
      A_GCTL:   bus_rdata = {28'd0, gctl};
      A_WCTL:   bus_rdata = {16'd0, flag, wden, 14'd0};
      default:  bus_rdata = 32'd0;
    endcase
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        locked,
  input logic        pre_act,
  input logic        flag,
  input logic        req,
  input logic [63:0] cnt,
  input logic [63:0] prd
);
  AST_REQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> flag); // R8
  AST_REQ_RISES_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $rose(flag)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag); // R9
  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(prd)); // R4
  AST_PRE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_act |=> $stable(cnt)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1 || cnt == 64'd0)); // R5
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .pre_act(pre_act),
  .flag(flag), .req(wd_rst_req), .cnt(cnt), .prd(prd)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam logic [5:0] CLO = 6'h10, CHI = 6'h14, PLO = 6'h18, PHI = 6'h1C,
                         TCT = 6'h20, GCT = 6'h24, WCT = 6'h28;
  localparam logic [31:0] K1 = 32'hA5C6_4000, K2 = 32'hDA7E_4000;

  logic clk = 0, rst_n = 0, we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic req;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wd_rst_req(req));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd64(output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(CLO, lo); rd(CHI, hi); d = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; we = 0;
    idle(2);
    rst_n = 1;
  endtask

  task automatic setup(input logic [31:0] plo, input logic [31:0] phi);
    wr(GCT, 32'hB); wr(TCT, 32'h80); wr(PLO, plo); wr(PHI, phi);
  endtask

  task automatic arm;
    wr(WCT, K1); wr(WCT, K2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] c;
    idle(1);
    do_reset;

    // R1 reset state
    foreach (d[i]) ;
    for (int a = 0; a < 7; a++) begin
      rd(6'(16 + 4 * a), d);
      chk("R1 reset value", d, 0);
    end
    chk("R1 rst_req low", req, 0);
    idle(1);

    // R2 readback before arming
    wr(CLO, 32'h1234_5678); wr(CHI, 32'h9ABC_DEF0);
    wr(PLO, 32'h0F0F_0F0F); wr(PHI, 32'hF0F0_F0F0);
    wr(TCT, 32'hFFFF_FFFF); wr(GCT, 32'hFFFF_FFFF); wr(WCT, 32'h0000_FFFF);
    rd(CLO, d); chk("R2 cnt lo", d, 32'h1234_5678);
    rd(CHI, d); chk("R2 cnt hi", d, 32'h9ABC_DEF0);
    rd(PLO, d); chk("R2 prd lo", d, 32'h0F0F_0F0F);
    rd(PHI, d); chk("R2 prd hi", d, 32'hF0F0_F0F0);
    idle(1);
    rd(TCT, d); chk("R2 tctl", d, 32'hC0);
    rd(GCT, d); chk("R2 gctl", d, 32'hF);
    rd(WCT, d); chk("R2 wctl", d, 32'h4000);
    idle(1);

    // R5 sweep of every gate combination
    for (int g = 0; g < 16; g++)
      for (int t = 0; t < 4; t++) begin
        do_reset;
        wr(GCT, 32'(g)); wr(TCT, 32'(t << 6)); wr(PHI, 32'h1);
        arm; idle(5);
        rd(CLO, d);
        chk($sformatf("R5 gate g=%0d t=%0d", g, t), d, (g == 11 && t != 0) ? 5 : 0);
        idle(1);
      end

    // R3 pre-active does not count; R4 lock
    do_reset; setup(0, 1);
    wr(WCT, K1); idle(4);
    rd(CLO, d); chk("R3 no count in pre-active", d, 0);
    idle(1);
    wr(CLO, 32'h55); wr(PLO, 32'h66); wr(TCT, 0); wr(GCT, 0); wr(WCT, 0);
    rd(CLO, d); chk("R4 cnt locked", d, 0);
    rd(PLO, d); chk("R4 prd locked", d, 0);
    rd(TCT, d); chk("R4 tctl locked", d, 32'h80);
    rd(GCT, d); chk("R4 gctl locked", d, 32'hB);
    idle(1);
    rd(WCT, d); chk("R4 enable locked", d, 32'h4000);
    idle(1);
    wr(WCT, K2); idle(3);
    rd(CLO, d); chk("R3 counts once active", d, 3);
    idle(1);
    wr(PLO, 32'h5); rd(PLO, d); chk("R4 prd locked when active", d, 0);
    idle(1);

    // R3 key without enable does not arm; R7 lone second key while disarmed
    do_reset;
    wr(WCT, 32'hA5C6_0000); wr(CLO, 32'h77);
    rd(CLO, d); chk("R3 key without enable leaves unlocked", d, 32'h77);
    idle(1);
    do_reset;
    wr(WCT, K2); wr(CLO, 32'h7);
    rd(CLO, d); chk("R7 second key while disarmed ignored", d, 7);
    idle(1);

    // R6 service
    do_reset; setup(0, 1); arm; idle(10);
    wr(WCT, K1); wr(WCT, K2);
    rd(CLO, d); chk("R6 service clears", d, 0);
    idle(4);
    rd(CLO, d); chk("R6 count resumes", d, 4);
    idle(1);

    // R7 broken sequences
    do_reset; setup(0, 1); arm;
    wr(WCT, K1); wr(WCT, 32'h1234_4000); wr(WCT, K2);
    rd(CLO, d); chk("R7 wrong key no service", d, 3);
    idle(1);
    do_reset; setup(0, 1); arm;
    wr(WCT, K2);
    rd(CLO, d); chk("R7 lone second key no service", d, 1);
    idle(1);
    do_reset; setup(0, 1); arm;
    wr(WCT, K1); wr(WCT, K1); wr(WCT, K2);
    rd(CLO, d); chk("R7 first key restarts sequence", d, 0);
    idle(1);
    do_reset; setup(0, 1); arm;
    wr(WCT, K1); wr(WCT, 32'h0000_4000); wr(WCT, K2);
    rd(CLO, d); chk("R7 zero key breaks sequence", d, 3);
    idle(1);
    do_reset; setup(0, 1);
    wr(WCT, K1); wr(WCT, 32'h1234_4000); wr(WCT, K2); idle(2);
    rd(CLO, d); chk("R7 pre-active kept after wrong key", d, 2);
    idle(1);

    // R8 expiry sweep over the period
    for (int p = 0; p <= 12; p++) begin
      int hi;
      do_reset; setup(32'(p), 0); arm; idle(p);
      rd(CLO, d); chk($sformatf("R8 count at period p=%0d", p), d, p);
      chk($sformatf("R8 no request yet p=%0d", p), req, 0);
      idle(1);
      rd(WCT, d); chk($sformatf("R8 flag set p=%0d", p), d, 32'hC000);
      hi = 0;
      for (int k = 0; k < 20; k++) begin
        if (req) hi++;
        idle(1);
      end
      chk($sformatf("R8 request length p=%0d", p), hi, 16);
      rd(CLO, d); chk($sformatf("R8 counter holds p=%0d", p), d, p);
      idle(1);
    end

    // R9 flag sticky
    wr(WCT, 32'h0); wr(WCT, K1); wr(WCT, K2); idle(20);
    rd(WCT, d); chk("R9 flag stays set", d, 32'hC000);
    chk("R9 no second request", req, 0);
    idle(1);

    // R10 service against expiry in the same cycle
    for (int n = 6; n <= 8; n++) begin
      do_reset; setup(8, 0); arm; idle(n);
      wr(WCT, K1); wr(WCT, K2);
      rd(WCT, d); chk($sformatf("R10 flag n=%0d", n), d[15], n >= 8);
      chk($sformatf("R10 request n=%0d", n), req, n >= 8);
      rd(CLO, d); chk($sformatf("R10 counter cleared n=%0d", n), d, 0);
      idle(1);
    end

    // R11 carry into high half
    do_reset; setup(0, 2);
    wr(CLO, 32'hFFFF_FFFE); arm; idle(3);
    rd64(c); chk("R11 carry", c, 64'h1_0000_0001);
    idle(1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule